// File: doc/BRIEF.md
# Atomic Sequence Memory Arbiter

This block sits between several processor request ports and one shared memory. Each port offers word requests (read or write, address, write data) with a valid/ready handshake. Each request also carries one extra flag, the atomic bit. When no port holds the memory, the arbiter picks one pending port per cycle in round-robin order. The winning request goes straight to the memory-side interface.

A port opens an exclusive run by issuing a request with the atomic bit set. From then on, only that port is served. Every later request from the owner that keeps the bit set extends the run. The owner's first request with the bit cleared is served and then closes the run. This lets a read, test and write of a lock word complete with no other port touching memory in between.

A watchdog guards against an owner that goes silent mid-run. If the owner has no accepted request for the configured number of cycles, exclusivity ends and a one-cycle error pulse is raised. A read returns its data to the requesting port one cycle after it is accepted. The current owner and the lock state are visible as outputs.

Top module: `atomic_seq_arbiter`

## Requirements
- R1: When a request with the atomic bit set is accepted from port p, then in the next cycle `lock_active` is 1 and `owner_id` equals p.
- R2: While `lock_active` is 1, no port other than `owner_id` sees `req_ready` high. This holds even when that other port's request has its atomic bit set.
- R3: While locked, an accepted owner request with the atomic bit set keeps the lock. An accepted owner request with the bit cleared is served, and `lock_active` is 0 in the next cycle, so other ports can then be granted.
- R4: A request with the atomic bit cleared that is accepted while unlocked is a single access, and `lock_active` stays 0.
- R5: While unlocked, the grant goes to the first requesting port in the order last granted + 1, + 2, … modulo the port count. After reset, the "last granted" port is the highest-numbered one, so port 0 has first priority.
- R6: At most one bit of `req_ready` is high in any cycle, and it is high only for a port whose `req_valid` is high.
- R7: Each read acceptance yields a response. In the cycle after acceptance, exactly the accepting port's bit of `rsp_valid` is high for that one cycle, and `rsp_data` carries the memory word. A write yields no `rsp_valid`.
- R8: In the cycle a request is accepted, `mem_req` is 1, and `mem_we`, `mem_addr` and `mem_wdata` carry that request's fields.
- R9: If the lock stays open for WDOG_CYCLES (64) consecutive cycles with no accepted owner request, the lock is released. `wdog_err` is 1 for exactly the one cycle after the release.
- R10: Any accepted owner request restarts the watchdog count, including one accepted on the cycle that would otherwise have expired it. In that case no release and no error occur.
- R11: After reset, `lock_active`, `wdog_err`, `rsp_valid` and `req_ready` (with no valid requests) are all 0, and `owner_id` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NPORT | Request pending, one bit per port |
| req_ready | output | NPORT | Request accepted this cycle, one bit per port |
| req_we | input | NPORT | 1 = write, 0 = read, per port |
| req_atomic | input | NPORT | Atomic bit per port; 1 keeps or opens exclusive ownership |
| req_addr | input | NPORT*AW | Word addresses, port i at bits [i*AW +: AW] |
| req_wdata | input | NPORT*DW | Write data, port i at bits [i*DW +: DW] |
| rsp_valid | output | NPORT | Read response pulse, one bit per port |
| rsp_data | output | DW | Read data for the port flagged in rsp_valid |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after a read strobe |
| owner_id | output | IW | Port that holds or last held the lock |
| lock_active | output | 1 | Exclusive run in progress |
| wdog_err | output | 1 | One-cycle pulse when the watchdog releases a lock |

## Verification
Two events can land in the same clock edge, and each pairing is forced on purpose.

The first pairing is the owner's own request and the watchdog's expiry. The bench opens a run, stays silent for exactly one cycle fewer than the limit, and then presents an owner request that is accepted on the expiring edge. It then checks that the lock survives with no error pulse. The same count without the request must end with a release and a single error pulse.

The second pairing is the release of a run and a grant to a port that was held off. Other ports stay pending through an entire read-test-write run. The bench then checks that the first port granted after the closing request is the next one in round-robin order from the owner.

// File: rtl/atomic_arb_pkg.sv
package atomic_arb_pkg;
  // Lock tracker state, kept as a named encoding for readability in waves.
  typedef enum logic {
    LK_FREE = 1'b0,
    LK_HELD = 1'b1
  } lock_state_e;

  // Fields of one accepted request that the lock tracker needs.
  typedef struct packed {
    logic valid;
    logic atomic;
  } accept_info_t;
endpackage

// File: rtl/rr_picker.sv
module rr_picker #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] last_q;
  logic          found;

  // Search starts at the port after the last one granted.
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    for (int i = 1; i <= N; i++) begin
      int idx;
      idx = (int'(last_q) + i) % N;
      if (!found && req[idx]) begin
        found        = 1'b1;
        gnt[idx]     = 1'b1;
        gnt_idx      = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= IW'(N - 1);
    else if (found) last_q <= gnt_idx;
  end

  // R5: a grant never goes to a port that is not requesting.
  assert_gnt_subset_R5: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~req) == '0);
endmodule

// File: rtl/lock_tracker.sv
module lock_tracker
  import atomic_arb_pkg::*;
#(
  parameter int N           = 4,
  parameter int IW          = (N > 1) ? $clog2(N) : 1,
  parameter int WDOG_CYCLES = 64,
  localparam int CW         = $clog2(WDOG_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  accept_info_t  acc,
  input  logic [IW-1:0] acc_idx,
  output logic          lock_active,
  output logic [IW-1:0] owner,
  output logic          wdog_err
);
  lock_state_e   state_q;
  logic [CW-1:0] idle_q;

  assign lock_active = (state_q == LK_HELD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= LK_FREE;
      owner    <= '0;
      idle_q   <= '0;
      wdog_err <= 1'b0;
    end else begin
      wdog_err <= 1'b0;
      if (acc.valid) begin
        // Only the owner can be accepted while held, so any acceptance counts.
        idle_q <= '0;
        if (acc.atomic) begin
          state_q <= LK_HELD;
          owner   <= acc_idx;
        end else begin
          state_q <= LK_FREE;
        end
      end else if (state_q == LK_HELD) begin
        if (idle_q == CW'(WDOG_CYCLES - 1)) begin
          state_q  <= LK_FREE;
          idle_q   <= '0;
          wdog_err <= 1'b1;
        end else begin
          idle_q <= idle_q + 1'b1;
        end
      end
    end
  end

  assert_take_lock_R1: assert property (@(posedge clk) disable iff (rst)
    (acc.valid && acc.atomic) |=> (lock_active && owner == $past(acc_idx)));

  assert_close_run_R3: assert property (@(posedge clk) disable iff (rst)
    (lock_active && acc.valid && !acc.atomic) |=> !lock_active);

  assert_single_stays_free_R4: assert property (@(posedge clk) disable iff (rst)
    (!lock_active && acc.valid && !acc.atomic) |=> !lock_active);

  assert_wdog_release_R9: assert property (@(posedge clk) disable iff (rst)
    wdog_err |-> (!lock_active && $past(lock_active)));

  assert_wdog_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    wdog_err |=> !wdog_err);

  assert_wdog_bound_R9: assert property (@(posedge clk) disable iff (rst)
    idle_q < CW'(WDOG_CYCLES));

  assert_wdog_restart_R10: assert property (@(posedge clk) disable iff (rst)
    acc.valid |=> !wdog_err);
endmodule

// File: rtl/atomic_seq_arbiter.sv
module atomic_seq_arbiter
  import atomic_arb_pkg::*;
#(
  parameter int NPORT       = 4,
  parameter int DW          = 32,
  parameter int AW          = 16,
  parameter int WDOG_CYCLES = 64,
  localparam int IW         = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPORT-1:0]    req_valid,
  output logic [NPORT-1:0]    req_ready,
  input  logic [NPORT-1:0]    req_we,
  input  logic [NPORT-1:0]    req_atomic,
  input  logic [NPORT*AW-1:0] req_addr,
  input  logic [NPORT*DW-1:0] req_wdata,
  output logic [NPORT-1:0]    rsp_valid,
  output logic [DW-1:0]       rsp_data,
  output logic                mem_req,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [DW-1:0]       mem_wdata,
  input  logic [DW-1:0]       mem_rdata,
  output logic [IW-1:0]       owner_id,
  output logic                lock_active,
  output logic                wdog_err
);
  logic [NPORT-1:0] eligible;
  logic [NPORT-1:0] gnt;
  logic [IW-1:0]    gnt_idx;
  logic [NPORT-1:0] owner_onehot;
  accept_info_t     acc;

  // While held, only the owner may compete.
  always_comb begin
    owner_onehot           = '0;
    owner_onehot[owner_id] = 1'b1;
    eligible = lock_active ? (req_valid & owner_onehot) : req_valid;
  end

  rr_picker #(.N(NPORT), .IW(IW)) u_pick (
    .clk     (clk),
    .rst     (rst),
    .req     (eligible),
    .gnt     (gnt),
    .gnt_idx (gnt_idx)
  );

  assign req_ready  = gnt;
  assign acc.valid  = |gnt;
  assign acc.atomic = req_atomic[gnt_idx];

  lock_tracker #(.N(NPORT), .IW(IW), .WDOG_CYCLES(WDOG_CYCLES)) u_lock (
    .clk         (clk),
    .rst         (rst),
    .acc         (acc),
    .acc_idx     (gnt_idx),
    .lock_active (lock_active),
    .owner       (owner_id),
    .wdog_err    (wdog_err)
  );

  // The memory sees the winning request in its acceptance cycle.
  assign mem_req   = acc.valid;
  assign mem_we    = acc.valid & req_we[gnt_idx];
  assign mem_addr  = req_addr[gnt_idx*AW +: AW];
  assign mem_wdata = req_wdata[gnt_idx*DW +: DW];

  // Read data comes from the memory's output register; route the pulse.
  always_ff @(posedge clk) begin
    if (rst) rsp_valid <= '0;
    else     rsp_valid <= (acc.valid && !req_we[gnt_idx]) ? gnt : '0;
  end
  assign rsp_data = mem_rdata;

  assert_one_ready_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_ready));

  assert_ready_needs_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (req_ready & ~req_valid) == '0);

  assert_held_off_R2: assert property (@(posedge clk) disable iff (rst)
    (lock_active && req_ready != '0) |-> req_ready[owner_id]);

  assert_read_rsp_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |=> $countones(rsp_valid) == 1);

  assert_no_write_rsp_R7: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && !mem_we) |=> rsp_valid == '0);

  assert_mem_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req == (req_ready != '0));
endmodule

// File: tb/atomic_seq_arbiter_test.sv
module atomic_seq_arbiter_test;
  localparam int NP = 4, DW = 32, AW = 16, WD = 64, IW = 2;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [NP-1:0] bv, bwe, bat;
  logic [AW-1:0] ba [NP];
  logic [DW-1:0] bd [NP];
  logic [NP*AW-1:0] addr_f;
  logic [NP*DW-1:0] wd_f;
  logic [NP-1:0] req_ready, rsp_valid;
  logic [DW-1:0] rsp_data, mem_wdata, mem_rdata;
  logic mem_req, mem_we, lock_active, wdog_err;
  logic [AW-1:0] mem_addr;
  logic [IW-1:0] owner_id;
  logic [DW-1:0] ram [256];

  always_comb
    for (int i = 0; i < NP; i++) begin
      addr_f[i*AW +: AW] = ba[i];
      wd_f[i*DW +: DW]   = bd[i];
    end

  atomic_seq_arbiter #(.NPORT(NP), .DW(DW), .AW(AW), .WDOG_CYCLES(WD)) uut (
    .clk(clk), .rst(rst), .req_valid(bv), .req_ready(req_ready), .req_we(bwe),
    .req_atomic(bat), .req_addr(addr_f), .req_wdata(wd_f), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .owner_id(owner_id),
    .lock_active(lock_active), .wdog_err(wdog_err));

  // Synchronous memory model: one cycle read latency.
  always @(posedge clk) begin
    if (mem_req && mem_we) ram[mem_addr[7:0]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= ram[mem_addr[7:0]];
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input int p, input bit we, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input bit at);
    bv[p] = 1'b1; bwe[p] = we; ba[p] = a; bd[p] = d; bat[p] = at;
  endtask

  // One full access from port p; returns at the negedge after acceptance.
  task automatic access(input int p, input bit we, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input bit at, input logic [DW-1:0] exp_rd,
                        input string tag);
    drive(p, we, a, d, at);
    #1;
    while (!req_ready[p]) begin @(negedge clk); #1; end
    chk(mem_req && mem_we == we && mem_addr == a && (!we || mem_wdata == d),
        {tag, " R8 mem fields"}, {mem_we, mem_addr}, {we, a});
    @(posedge clk); @(negedge clk);
    bv[p] = 1'b0;
    if (we) chk(rsp_valid == '0, {tag, " R7 no write rsp"}, rsp_valid, 0);
    else begin
      chk(rsp_valid == (NP'(1) << p), {tag, " R7 rsp port"}, rsp_valid, NP'(1) << p);
      chk(rsp_data == exp_rd, {tag, " R7 rsp data"}, rsp_data, exp_rd);
    end
  endtask

  task automatic t_reset;
    chk(lock_active == 0 && wdog_err == 0 && owner_id == 0, "R11 lock/err/owner",
        {lock_active, wdog_err, owner_id}, 0);
    chk(rsp_valid == 0 && req_ready == 0, "R11 ready/rsp", {rsp_valid, req_ready}, 0);
  endtask

  task automatic t_single;
    access(1, 1, 16'h0010, 32'hCAFE_0001, 0, 0, "single wr");
    chk(!lock_active, "R4 single write leaves unlocked", lock_active, 0);
    access(1, 0, 16'h0010, 0, 0, 32'hCAFE_0001, "single rd");
    chk(!lock_active, "R4 single read leaves unlocked", lock_active, 0);
  endtask

  task automatic t_round_robin;
    // Last grant was port 1: expected order 2, 3, 0.
    int order[3] = '{2, 3, 0};
    drive(0, 1, 16'h20, 32'h100, 0);
    drive(2, 1, 16'h22, 32'h102, 0);
    drive(3, 1, 16'h23, 32'h103, 0);
    foreach (order[k]) begin
      #1;
      chk(req_ready == (NP'(1) << order[k]), "R5 rr order / R6 onehot",
          req_ready, NP'(1) << order[k]);
      @(posedge clk); @(negedge clk);
      bv[order[k]] = 1'b0;
    end
  endtask

  task automatic t_atomic_run;
    // Last grant port 0. Port 2 opens a lock read-test-write on addr 5.
    access(3, 1, 16'h5, 32'h0, 0, 0, "init lock word");
    drive(0, 1, 16'h30, 32'hAAAA, 0);
    drive(1, 1, 16'h5, 32'hDEAD, 1);           // non-owner atomic try
    access(2, 0, 16'h5, 0, 1, 32'h0, "atomic rd");  // port 2 follows 1? see below
  endtask

  task automatic t_lock_sequence;
    // Fresh priority state: last grant was port 3 (init write), so port 0 would
    // win first; hold others off until port 2 is granted alone.
    bv = '0;
    access(2, 0, 16'h5, 0, 1, 32'h0, "R1 atomic rd");
    chk(lock_active && owner_id == 2, "R1 lock taken by port 2", {lock_active, owner_id}, {1'b1, 2'd2});
    drive(0, 1, 16'h30, 32'hAAAA, 0);
    drive(1, 1, 16'h5, 32'hDEAD, 1);
    repeat (3) begin
      #1;
      chk(req_ready == 0, "R2 others held off", req_ready, 0);
      @(negedge clk);
    end
    access(2, 1, 16'h5, 32'h1, 1, 0, "R3 atomic wr");
    chk(lock_active && owner_id == 2, "R3 lock kept by atomic bit", lock_active, 1);
    #1 chk(req_ready == 0, "R2 held off after owner wr", req_ready, 0);
    // Closing read: owner bit cleared. Others still pending.
    drive(2, 0, 16'h5, 0, 0);
    #1 chk(req_ready == 4'b0100, "R2 only owner ready", req_ready, 4'b0100);
    @(posedge clk); @(negedge clk);
    bv[2] = 1'b0;
    chk(rsp_valid == 4'b0100 && rsp_data == 32'h1, "R7 lock word reads 1", rsp_data, 1);
    chk(!lock_active, "R3 lock released after final", lock_active, 0);
    // Next in order after 2: port 3 idle, so port 0, with port 1 atomic later.
    #1 chk(req_ready == 4'b0001, "R3/R5 next grant after release", req_ready, 4'b0001);
    @(posedge clk); @(negedge clk);
    bv[0] = 1'b0;
    #1 chk(req_ready == 4'b0010, "R5 port 1 follows", req_ready, 4'b0010);
    @(posedge clk); @(negedge clk);
    bv[1] = 1'b0;
    chk(lock_active && owner_id == 1, "R1 port 1 owns", {lock_active, owner_id}, {1'b1, 2'd1});
    access(1, 0, 16'h5, 0, 0, 32'hDEAD, "R3 port 1 closes");
    chk(!lock_active, "R3 released", lock_active, 0);
  endtask

  task automatic t_wdog_restart;
    access(1, 0, 16'h20, 0, 1, 32'h100, "wd restart open");
    repeat (WD - 1) @(negedge clk);
    chk(lock_active, "R10 lock still open before expiry", lock_active, 1);
    drive(1, 0, 16'h22, 0, 1);
    #1 chk(req_ready == 4'b0010, "R10 owner ready on expiring cycle", req_ready, 4'b0010);
    @(posedge clk); @(negedge clk);
    bv[1] = 1'b0;
    chk(lock_active && !wdog_err, "R10 no release when owner lands on expiry",
        {lock_active, wdog_err}, 2'b10);
    access(1, 1, 16'h24, 32'h77, 0, 0, "wd restart close");
    chk(!lock_active, "R3 closed", lock_active, 0);
  endtask

  task automatic t_wdog_expire;
    access(3, 0, 16'h23, 0, 1, 32'h103, "wd open");
    drive(0, 0, 16'h24, 0, 0);
    repeat (WD - 1) @(negedge clk);
    #1;
    chk(lock_active && !wdog_err, "R9 still held at count-1", {lock_active, wdog_err}, 2'b10);
    chk(req_ready == 0, "R2 port 0 held off during silence", req_ready, 0);
    @(negedge clk);
    chk(!lock_active && wdog_err, "R9 release and error", {lock_active, wdog_err}, 2'b01);
    #1 chk(req_ready == 4'b0001, "R9 waiting port granted after release", req_ready, 4'b0001);
    @(posedge clk); @(negedge clk);
    bv[0] = 1'b0;
    chk(!wdog_err, "R9 error is one cycle", wdog_err, 0);
    chk(rsp_valid == 4'b0001 && rsp_data == 32'h77, "R7 port 0 read", rsp_data, 32'h77);
  endtask

  initial begin
    bv = '0; bwe = '0; bat = '0;
    for (int i = 0; i < NP; i++) begin ba[i] = '0; bd[i] = '0; end
    for (int i = 0; i < 256; i++) ram[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_single();
    t_round_robin();
    access(3, 1, 16'h5, 32'h0, 0, 0, "init lock word");
    t_lock_sequence();
    t_wdog_restart();
    t_wdog_expire();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule